// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The block watches a received Ethernet frame as a stream of bytes and decides whether the frame goes on to the application or is dropped. It captures the destination address from bytes 0 to 5 and the source address from bytes 6 to 11. Each address arrives least significant byte first, so the first byte received becomes address bits 7:0.

The destination address is checked against programmable perfect-match slots, a 64-bit hash table and the broadcast pattern. The source address is checked against the slots marked for source comparison.

One cycle after the last byte of a frame, the block pulses a result. The result carries a pass flag, the destination filter outcome and the raw source-address match. A control register picks the filtering mode. The address slots and the hash table are static inputs that the integrator drives.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: `res_valid_o` is high for exactly the cycle after each accepted byte that carries `rx_eof_i`, and low in every other cycle. All outputs are 0 during reset and after it.
- R2: While control bit 31 (receive-all) is set, `res_pass_o` is 1. `res_da_ok_o` and `res_sa_hit_o` still report the computed filter results.
- R3: While receive-all is clear, `res_pass_o` equals the DA pass result AND (control bit 9 clear OR the SA check succeeds). With bit 9 clear, an SA mismatch does not drop the frame.
- R4: The DA perfect match is true when any slot with its enable bit set and its SA flag clear holds the captured destination address. Bit 0 of the first byte set means multicast. An all-ones destination address always passes the DA filter.
- R5: The hash index is bits 31:26 of the complemented, reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over the six destination bytes. Control bit 1 enables hashing for unicast and bit 2 for multicast. With hashing enabled and bit 10 clear, only the hash-table bit at that index decides the DA result.
- R6: With hashing enabled for the address type and control bit 10 set, the DA passes on a hash hit or a perfect match.
- R7: Control bit 3 inverts the DA result for every address except broadcast.
- R8: `res_sa_hit_o` is 1 when any enabled slot with its SA flag set equals the captured source address. A disabled slot never matches.
- R9: With control bit 8 clear, the SA check succeeds on a match. With bit 8 set, it succeeds on a mismatch.
- R10: A frame of fewer than 12 bytes reports 0 on both `res_da_ok_o` and `res_sa_hit_o`. Such a frame passes only under receive-all.
- R11: The control register resets to zero. Only bits 31, 10, 9, 8, 3, 2 and 1 are writable, and every other bit reads as zero.
- R12: A control write made in the same cycle as an end-of-frame byte is applied only to later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | Marks the first byte of a frame |
| rx_eof_i | input | 1 | Marks the last byte of a frame |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control write data |
| cfg_rdata_o | output | 32 | Control register contents |
| slot_addr_i | input | 192 | Perfect-match addresses, slot k at bits 48k+47:48k |
| slot_en_i | input | 4 | Per-slot enable |
| slot_is_sa_i | input | 4 | Per-slot flag: 1 compares the source address, 0 the destination |
| hash_tbl_i | input | 64 | Hash table, one bit per index |
| res_valid_o | output | 1 | Result strobe |
| res_pass_o | output | 1 | Frame is passed to the application |
| res_da_ok_o | output | 1 | Destination filter passed |
| res_sa_hit_o | output | 1 | Source address matched a slot |

## Verification
A control write and a frame decision can occur in the same cycle. The bench provokes this by raising the write strobe on the end-of-frame byte, with a value that would reverse the verdict. The reference model evaluates the frame with the control value held before that edge, and only then applies the write. Any use of the new value therefore shows up as a pass mismatch, followed by a readback check of the written value.

Two frames sent back to back with no idle cycle put one frame's last byte right before the next frame's first byte. This checks that the result pulse and the new frame's capture do not disturb each other.

// File: rtl/eth_af_pkg.sv
package eth_af_pkg;
  localparam int CB_RX_ALL = 31;
  localparam int CB_HPF    = 10;
  localparam int CB_SAF    = 9;
  localparam int CB_SAINV  = 8;
  localparam int CB_DAINV  = 3;
  localparam int CB_HMC    = 2;
  localparam int CB_HUC    = 1;
  localparam logic [31:0] CTRL_MASK =
    (32'h1 << CB_RX_ALL) | (32'h1 << CB_HPF) | (32'h1 << CB_SAF) | (32'h1 << CB_SAINV) |
    (32'h1 << CB_DAINV) | (32'h1 << CB_HMC) | (32'h1 << CB_HUC);
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_af_ctrl.sv
module eth_af_ctrl
  import eth_af_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctrl_o
);
  logic [31:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i & CTRL_MASK;
  end

  assign ctrl_o = ctrl_q;

  a_r11_masked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ctrl_o == ($past(wdata_i) & CTRL_MASK));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/eth_af_capture.sv
module eth_af_capture
  import eth_af_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int HDR = 2 * ADDR_BYTES,
  localparam int CNT_W = $clog2(HDR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              sof_i,
  output logic [CNT_W-1:0]  cnt_nxt_o,
  output logic [ADDR_W-1:0] da_nxt_o,
  output logic [ADDR_W-1:0] sa_nxt_o,
  output logic [31:0]       crc_nxt_o
);
  localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR);

  logic [CNT_W-1:0]  cnt_q, base_cnt;
  logic [ADDR_W-1:0] da_q, sa_q;
  logic [31:0]       crc_q, crc_base;

  always_comb begin
    base_cnt  = sof_i ? '0 : cnt_q;
    crc_base  = sof_i ? '1 : crc_q;
    cnt_nxt_o = cnt_q;
    da_nxt_o  = da_q;
    sa_nxt_o  = sa_q;
    crc_nxt_o = crc_q;
    if (valid_i) begin
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (base_cnt == CNT_W'(k)) begin
          da_nxt_o[k*8 +: 8] = data_i;
          crc_nxt_o = crc32_step(crc_base, data_i);
        end
        if (base_cnt == CNT_W'(k + ADDR_BYTES)) sa_nxt_o[k*8 +: 8] = data_i;
      end
      // saturate once the header is complete
      cnt_nxt_o = (base_cnt == HDR_C) ? base_cnt : base_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      da_q  <= '0;
      sa_q  <= '0;
      crc_q <= '1;
    end else begin
      cnt_q <= cnt_nxt_o;
      da_q  <= da_nxt_o;
      sa_q  <= sa_nxt_o;
      crc_q <= crc_nxt_o;
    end
  end

  a_r10_cnt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= HDR_C);
  a_r10_sof_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/eth_af_match.sv
module eth_af_match #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
  input  logic [NUM_SLOTS-1:0]        slot_en_i,
  input  logic [NUM_SLOTS-1:0]        slot_is_sa_i,
  input  logic                        sel_sa_i,
  output logic                        hit_o
);
  logic [NUM_SLOTS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign hit_vec[g] = slot_en_i[g] && (slot_is_sa_i[g] == sel_sa_i) &&
                        (slot_addr_i[g*ADDR_W +: ADDR_W] == addr_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_af_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS = 6,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int HDR = 2 * ADDR_BYTES,
  localparam int CNT_W = $clog2(HDR + 1),
  localparam int HASH_SIZE = 1 << HASH_BITS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rx_valid_i,
  input  logic [7:0]                  rx_data_i,
  input  logic                        rx_sof_i,
  input  logic                        rx_eof_i,
  input  logic                        cfg_wr_i,
  input  logic [31:0]                 cfg_wdata_i,
  output logic [31:0]                 cfg_rdata_o,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
  input  logic [NUM_SLOTS-1:0]        slot_en_i,
  input  logic [NUM_SLOTS-1:0]        slot_is_sa_i,
  input  logic [HASH_SIZE-1:0]        hash_tbl_i,
  output logic                        res_valid_o,
  output logic                        res_pass_o,
  output logic                        res_da_ok_o,
  output logic                        res_sa_hit_o
);
  logic [31:0]          ctrl;
  logic [CNT_W-1:0]     cnt_nxt;
  logic [ADDR_W-1:0]    da_nxt, sa_nxt;
  logic [31:0]          crc_nxt, crc_fin;
  logic [HASH_BITS-1:0] hidx;
  logic perf_hit, sa_hit, hash_hit, hash_on, is_mc, is_bc;
  logic da_raw, da_ok, hdr_done, da_stat, sa_stat, sa_ok, pass, fire;

  eth_af_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i), .ctrl_o(ctrl)
  );

  eth_af_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .data_i(rx_data_i), .sof_i(rx_sof_i),
    .cnt_nxt_o(cnt_nxt), .da_nxt_o(da_nxt), .sa_nxt_o(sa_nxt), .crc_nxt_o(crc_nxt)
  );

  eth_af_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_da_match (
    .addr_i(da_nxt), .slot_addr_i, .slot_en_i, .slot_is_sa_i, .sel_sa_i(1'b0), .hit_o(perf_hit)
  );

  eth_af_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_sa_match (
    .addr_i(sa_nxt), .slot_addr_i, .slot_en_i, .slot_is_sa_i, .sel_sa_i(1'b1), .hit_o(sa_hit)
  );

  assign fire     = rx_valid_i && rx_eof_i;
  assign is_mc    = da_nxt[0];
  assign is_bc    = &da_nxt;
  assign crc_fin  = ~crc_nxt;
  assign hidx     = crc_fin[31 -: HASH_BITS];
  assign hash_hit = hash_tbl_i[hidx];
  assign hash_on  = is_mc ? ctrl[CB_HMC] : ctrl[CB_HUC];

  always_comb begin
    if (!hash_on)          da_raw = perf_hit;
    else if (ctrl[CB_HPF]) da_raw = perf_hit | hash_hit;
    else                   da_raw = hash_hit;
  end

  assign da_ok    = is_bc | (da_raw ^ ctrl[CB_DAINV]);
  assign hdr_done = (cnt_nxt == CNT_W'(HDR));
  assign da_stat  = hdr_done & da_ok;
  assign sa_stat  = hdr_done & sa_hit;
  assign sa_ok    = sa_stat ^ ctrl[CB_SAINV];
  assign pass     = ctrl[CB_RX_ALL] | (da_stat & (~ctrl[CB_SAF] | sa_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_pass_o   <= 1'b0;
      res_da_ok_o  <= 1'b0;
      res_sa_hit_o <= 1'b0;
    end else begin
      res_valid_o  <= fire;
      res_pass_o   <= fire & pass;
      res_da_ok_o  <= fire & da_stat;
      res_sa_hit_o <= fire & sa_stat;
    end
  end

  assign cfg_rdata_o = ctrl;

  a_r1_result_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> res_valid_o);
  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !res_valid_o);
  a_r2_rx_all_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && ctrl[CB_RX_ALL]) |=> res_pass_o);
  a_r3_sa_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !ctrl[CB_RX_ALL] && ctrl[CB_SAF]) |=>
      (!res_pass_o || (res_sa_hit_o != $past(ctrl[CB_SAINV]))));
  a_r7_bcast_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && hdr_done && (&da_nxt)) |=> res_da_ok_o);
  a_r10_short_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !hdr_done) |=> (!res_da_ok_o && !res_sa_hit_o));
endmodule

// File: tb/eth_rx_addr_filter_test.sv
module eth_rx_addr_filter_test;
  localparam int NS = 4;
  localparam logic [31:0] WMASK = 32'h8000_070E;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, rx_valid, rx_sof, rx_eof, cfg_wr;
  logic [7:0] rx_data;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [47:0] slot [NS];
  logic [NS*48-1:0] slot_flat;
  logic [NS-1:0] slot_en, slot_sa;
  logic [63:0] htbl;
  logic res_valid, res_pass, res_da, res_sa;

  always_comb for (int k = 0; k < NS; k++) slot_flat[k*48 +: 48] = slot[k];

  eth_rx_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .slot_addr_i(slot_flat), .slot_en_i(slot_en),
    .slot_is_sa_i(slot_sa), .hash_tbl_i(htbl), .res_valid_o(res_valid),
    .res_pass_o(res_pass), .res_da_ok_o(res_da), .res_sa_hit_o(res_sa)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [7:0] fr[$];
  logic [7:0] tx[$];
  logic [31:0] m_ctrl = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mac(input logic [7:0] a, b, c, d, e, f);
    return {f, e, d, c, b, a};
  endfunction

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) c = (c >> 1) ^ (32'hEDB8_8320 & {32{c[0] ^ a[n]}});
    c = ~c;
    return c[31:26];
  endfunction

  task automatic ref_eval(output bit p, output bit d, output bit s);
    logic [47:0] da, sa;
    bit perf, hon, raw;
    d = 0; s = 0;
    if (fr.size() >= 12) begin
      for (int k = 0; k < 6; k++) begin
        da[k*8 +: 8] = fr[k];
        sa[k*8 +: 8] = fr[k+6];
      end
      perf = 0;
      for (int k = 0; k < NS; k++) begin
        if (slot_en[k] && !slot_sa[k] && slot[k] == da) perf = 1;
        if (slot_en[k] && slot_sa[k] && slot[k] == sa) s = 1;
      end
      hon = da[0] ? m_ctrl[2] : m_ctrl[1];
      if (!hon) raw = perf;
      else if (m_ctrl[10]) raw = perf || htbl[hash_of(da)];
      else raw = htbl[hash_of(da)];
      d = (da == '1) ? 1'b1 : (raw ^ m_ctrl[3]);
    end
    p = m_ctrl[31] || (d && (!m_ctrl[9] || (s ^ m_ctrl[8])));
  endtask

  // reference model, compared every cycle
  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      fr.delete();
      m_ctrl = 0;
      chk(res_valid, 0, "R1", "valid in reset");
      chk(cfg_rdata, 0, "R11", "ctrl in reset");
    end else begin
      bit ev, p, d, s;
      ev = rx_valid && rx_eof;
      if (rx_valid) begin
        if (rx_sof) fr.delete();
        fr.push_back(rx_data);
      end
      chk(res_valid, ev, "R1", "valid");
      if (ev) begin
        ref_eval(p, d, s);
        chk(res_pass, p, cur_req, "pass");
        chk(res_da, d, cur_req, "da_ok");
        chk(res_sa, s, cur_req, "sa_hit");
      end
      if (cfg_wr) m_ctrl = cfg_wdata & WMASK;
      chk(cfg_rdata, m_ctrl, "R11", "ctrl readback");
    end
  end

  task automatic mk(input logic [47:0] da, input logic [47:0] sa, input int len);
    tx.delete();
    for (int k = 0; k < 6; k++) tx.push_back(da[k*8 +: 8]);
    for (int k = 0; k < 6; k++) tx.push_back(sa[k*8 +: 8]);
    for (int k = 12; k < len; k++) tx.push_back(8'(k));
    while (tx.size() > len) void'(tx.pop_back());
  endtask

  task automatic send(input int gap, input bit wr_eof, input logic [31:0] wv);
    for (int i = 0; i < tx.size(); i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = tx[i];
      rx_sof = (i == 0); rx_eof = (i == tx.size() - 1);
      cfg_wr = wr_eof && rx_eof; cfg_wdata = wv;
    end
    if (gap > 0) begin
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0; cfg_wr = 0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic frame(input logic [47:0] da, input logic [47:0] sa);
    mk(da, sa, 16);
    send(2, 0, 0);
  endtask

  logic [47:0] da_p0, da_pm, da_unk, da_hu, da_hm, da_bc, sa_ok, sa_off, sa_unk;

  initial begin
    rst_n = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0; cfg_wr = 0; cfg_wdata = 0;
    da_p0 = mac(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    da_pm = mac(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    da_unk = mac(8'h06, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50);
    da_hu = mac(8'h04, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5);
    da_hm = mac(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h07);
    da_bc = '1;
    sa_ok = mac(8'h00, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE);
    sa_off = mac(8'h00, 8'h99, 8'h88, 8'h77, 8'h66, 8'h55);
    sa_unk = mac(8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);
    slot[0] = da_p0; slot[1] = da_pm; slot[2] = sa_ok; slot[3] = sa_off;
    slot_en = 4'b0111; slot_sa = 4'b1100;
    htbl = '0;
    htbl[hash_of(da_hu)] = 1'b1;
    htbl[hash_of(da_hm)] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R4";   // perfect DA, unknown, broadcast, multicast slot
    frame(da_p0, sa_unk); frame(da_unk, sa_unk); frame(da_bc, sa_unk); frame(da_pm, sa_unk);
    cur_req = "R8";   // SA status with filter off: enabled hit, disabled slot
    frame(da_p0, sa_ok); frame(da_p0, sa_off);
    cur_req = "R3";   // SA filter on
    wr_ctrl(32'h0000_0200);
    frame(da_p0, sa_ok); frame(da_p0, sa_unk); frame(da_unk, sa_ok);
    cur_req = "R9";
    wr_ctrl(32'h0000_0300);
    frame(da_p0, sa_ok); frame(da_p0, sa_unk);
    cur_req = "R5";   // hash only for unicast
    wr_ctrl(32'h0000_0002);
    frame(da_hu, sa_unk); frame(da_p0, sa_unk); frame(da_pm, sa_unk); frame(da_hm, sa_unk);
    wr_ctrl(32'h0000_0004);  // hash only for multicast
    frame(da_hm, sa_unk); frame(da_pm, sa_unk); frame(da_p0, sa_unk);
    cur_req = "R6";
    wr_ctrl(32'h0000_0406);
    frame(da_hu, sa_unk); frame(da_p0, sa_unk); frame(da_unk, sa_unk); frame(da_pm, sa_unk);
    cur_req = "R7";
    wr_ctrl(32'h0000_0008);
    frame(da_p0, sa_unk); frame(da_unk, sa_unk); frame(da_bc, sa_unk);
    cur_req = "R2";
    wr_ctrl(32'h8000_0200);
    frame(da_unk, sa_unk); frame(da_p0, sa_ok);
    cur_req = "R10";  // short frames, with and without receive-all
    mk(da_p0, sa_ok, 8); send(2, 0, 0);
    mk(da_p0, sa_ok, 11); send(2, 0, 0);
    wr_ctrl(32'h0);
    mk(da_p0, sa_ok, 11); send(2, 0, 0);
    mk(da_p0, sa_ok, 1); send(2, 0, 0);
    mk(da_p0, sa_ok, 12); send(2, 0, 0);
    cur_req = "R11";
    wr_ctrl(32'hFFFF_FFFF);
    wr_ctrl(32'h7FFF_F8F1);
    wr_ctrl(32'h0);
    cur_req = "R12";  // write on eof byte reverses verdict only for next frame
    mk(da_unk, sa_unk, 16); send(0, 1, 32'h8000_0000);
    mk(da_unk, sa_unk, 16); send(0, 1, 32'h0000_0200);
    mk(da_p0, sa_unk, 16); send(2, 0, 0);
    cur_req = "R1";   // back to back and long frames
    wr_ctrl(32'h0);
    mk(da_p0, sa_ok, 14); send(0, 0, 0);
    mk(da_unk, sa_ok, 13); send(0, 0, 0);
    mk(da_bc, sa_ok, 64); send(3, 0, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule